// File: doc/BRIEF.md
# SDRAM Burst Command Controller

This block turns host burst requests into SDRAM command sequences. After reset it waits a fixed settling period. It then precharges every bank and loads the mode register with the default burst length and the CAS latency. Only after that does it accept work. Each request carries a flat word address, a direction and a burst-length code. The controller splits the address into bank, row and column. It opens the row with ACTIVE, which selects bank and row on the multiplexed address pins. It then issues READ or WRITE with the starting column, moves the burst words and leaves every bank closed before it accepts the next request.

The burst length can be changed from one request to the next. When a request asks for a length other than the one currently programmed, the controller loads the mode register again before the ACTIVE. In full-page mode the device would keep streaming along the row, so the controller cuts the burst with BURST TERMINATE after the number of words the host asked for. Fixed-length writes close their row with auto precharge. Reads and full-page writes close it with an explicit PRECHARGE. For each word the host receives a per-word strobe and the column that word occupies, including the wrap-around the device applies.

States: `ST_INIT` (power-up wait) → `ST_PRE_ALL` → `ST_PRE_WAIT` → `ST_MODE` → `ST_MODE_WAIT` → `ST_IDLE`. From `ST_IDLE`, an accepted request goes to `ST_MODE` when the length changes, otherwise to `ST_ACT`. `ST_MODE_WAIT` goes to `ST_ACT` if a request is pending, else to `ST_IDLE`. `ST_ACT` → `ST_ACT_WAIT`, then `ST_WRITE` → `ST_WR_BURST` or `ST_READ` → `ST_RD_BURST`. A fixed write ends with `ST_WR_BURST` (or `ST_WRITE` for one word) → `ST_RECOVER` → `ST_IDLE`. A read or full-page write ends with `ST_CLOSE` → `ST_CLOSE_WAIT` → `ST_IDLE`.

Top module: `sdram_burst_ctrl`

## Requirements
- R1: After reset the command is NOP for INIT_CYC cycles. Then PRECHARGE with address bit 10 high is issued. T_RP cycles later LOAD MODE is issued with the length code on address bits 2:0 and CAS_LAT on bits 6:4. req_ready rises T_MRD cycles after LOAD MODE.
- R2: Commands are driven as {cs_n, ras_n, cas_n, we_n}: 0111 NOP, 0011 ACTIVE, 0101 READ, 0100 WRITE, 0010 PRECHARGE, 0110 BURST TERMINATE, 0000 LOAD MODE.
- R3: req_addr is {bank, row, column}, with the column in the low COL_W bits. ACTIVE drives the bank on sd_ba and the row on sd_addr.
- R4: READ or WRITE follows ACTIVE by exactly T_RCD cycles, with the bank on sd_ba and the start column on sd_addr[COL_W-1:0].
- R5: The length codes are 0, 1, 2 and 3 for 1, 2, 4 and 8 words, and 7 for full page, where req_words gives the count. If the code differs from the programmed one, LOAD MODE is issued in the first cycle after acceptance and ACTIVE follows T_MRD cycles later. Otherwise ACTIVE comes first.
- R6: For a write, wr_ready is high for n consecutive cycles starting in the WRITE cycle. In those cycles sd_dq_oe is high and sd_dq_out equals wr_data.
- R7: A fixed-length WRITE carries address bit 10 high (auto precharge), and no PRECHARGE command follows it. req_ready returns T_WR+T_RP cycles after the last word.
- R8: For a read, rd_valid is high for n consecutive cycles starting CAS_LAT cycles after READ, and rd_data equals sd_dq_in. With the default timing, ACTIVE to the last word spans 4+n cycles.
- R9: In full-page mode, BURST TERMINATE is issued n cycles after READ or WRITE, and the WRITE carries address bit 10 low. Fixed lengths never issue BURST TERMINATE.
- R10: A read issues PRECHARGE (bit 10 low, bank on sd_ba) CAS_LAT+n cycles after READ. A full-page write issues it one cycle after BURST TERMINATE. req_ready returns T_RP cycles after the PRECHARGE.
- R11: xfer_col gives each word's column: it wraps inside the n-aligned block for 2, 4 or 8 words and inside the row for full page.
- R12: req_ready is high only while idle. A request is accepted on a cycle where req_valid and req_ready are both high, and req_ready stays low until that request's sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | BANK_W+ROW_W+COL_W | Word address {bank,row,column} |
| req_len | input | 3 | Burst-length code |
| req_words | input | COL_W+1 | Word count for full-page mode |
| wr_ready | output | 1 | Write word taken this cycle |
| wr_data | input | DATA_W | Write word |
| rd_valid | output | 1 | Read word present this cycle |
| rd_data | output | DATA_W | Read word |
| xfer_col | output | COL_W | Column of the current word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_addr | output | ROW_W | Multiplexed address |
| sd_dq_out | output | DATA_W | Data toward device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DATA_W | Data from device |

## Verification
The assertions assume the host only uses length codes 0 to 3 or 7. They also assume that a full-page request asks for between one and 2^COL_W words, and that the device returns read data exactly CAS_LAT cycles after READ. The stimulus uses only the legal codes, keeps full-page counts small and inside that range, and models the device by driving sd_dq_in with a value tied to the cycle index. The sweep covers every length code against every start offset inside an 8-word block, in both directions. It also covers full-page bursts that cross the end of the row and length changes that force the mode register to be reloaded.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MODE = 4'b0000,
        CMD_PRE  = 4'b0010,
        CMD_ACT  = 4'b0011,
        CMD_WR   = 4'b0100,
        CMD_RD   = 4'b0101,
        CMD_TERM = 4'b0110,
        CMD_NOP  = 4'b0111
    } cmd_t;

    typedef enum logic [3:0] {
        ST_INIT, ST_PRE_ALL, ST_PRE_WAIT, ST_MODE, ST_MODE_WAIT, ST_IDLE,
        ST_ACT, ST_ACT_WAIT, ST_WRITE, ST_WR_BURST, ST_READ, ST_RD_BURST,
        ST_CLOSE, ST_CLOSE_WAIT, ST_RECOVER
    } state_t;

    localparam logic [2:0] LEN_FULL = 3'd7;

endpackage

// File: rtl/sdram_addr_split.sv
module sdram_addr_split #(
    parameter int BANK_W = 1,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    assign col  = addr[COL_W-1:0];
    assign row  = addr[COL_W +: ROW_W];
    assign bank = addr[ADDR_W-1 -: BANK_W];
endmodule

// File: rtl/sdram_burst_col.sv
module sdram_burst_col #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic [COL_W-1:0] beat_idx,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] wrap_mask;
    logic [COL_W-1:0] sum;

    always_comb begin
        case (len_code)
            3'd0:    wrap_mask = '0;
            3'd1:    wrap_mask = COL_W'(1);
            3'd2:    wrap_mask = COL_W'(3);
            3'd3:    wrap_mask = COL_W'(7);
            default: wrap_mask = '1;
        endcase
    end

    assign sum = start_col + beat_idx;
    assign col = (start_col & ~wrap_mask) | (sum & wrap_mask);
endmodule

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
    parameter int TW      = 5,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= TW'(RST_VAL);
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sdram_burst_ctrl.sv
module sdram_burst_ctrl
    import sdram_ctrl_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int BANK_W   = 1,
    parameter int ROW_W    = 12,
    parameter int COL_W    = 9,
    parameter int CAS_LAT  = 2,
    parameter int T_RCD    = 2,
    parameter int T_RP     = 2,
    parameter int T_MRD    = 2,
    parameter int T_WR     = 2,
    parameter int INIT_CYC = 16,
    parameter logic [2:0] DEF_LEN = 3'd3,
    localparam int ADDR_W  = BANK_W + ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_len,
    input  logic [COL_W:0]    req_words,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [COL_W-1:0]  xfer_col,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_in
);
    localparam int NW = COL_W + 1;
    localparam int BW = COL_W + 2;
    localparam int TW = $clog2(INIT_CYC + T_WR + T_RP + T_MRD + T_RCD + 2);
    localparam logic [BW-1:0] CL_B = BW'(CAS_LAT);

    function automatic logic [NW-1:0] words_of(input logic [2:0] len,
                                               input logic [NW-1:0] cnt);
        case (len)
            3'd0:    return NW'(1);
            3'd1:    return NW'(2);
            3'd2:    return NW'(4);
            3'd3:    return NW'(8);
            default: return cnt;
        endcase
    endfunction

    state_t st, st_nx;
    cmd_t   cmd;

    logic              l_write, pend;
    logic [BANK_W-1:0] l_bank;
    logic [ROW_W-1:0]  l_row;
    logic [COL_W-1:0]  l_col;
    logic [2:0]        l_len, cur_len;
    logic [NW-1:0]     l_n;
    logic [BW-1:0]     beat, l_n_b, rd_k;
    logic [COL_W-1:0]  beat_k;
    logic              full;

    logic [BANK_W-1:0] a_bank;
    logic [ROW_W-1:0]  a_row;
    logic [COL_W-1:0]  a_col;

    logic              tmr_load, tmr_done;
    logic [TW-1:0]     tmr_val;

    sdram_addr_split #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_split (
        .addr(req_addr), .bank(a_bank), .row(a_row), .col(a_col)
    );

    sdram_wait_timer #(.TW(TW), .RST_VAL(INIT_CYC - 1)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    sdram_burst_col #(.COL_W(COL_W)) u_col (
        .start_col(l_col), .len_code(l_len), .beat_idx(beat_k), .col(xfer_col)
    );

    assign full  = (l_len == LEN_FULL);
    assign l_n_b = BW'(l_n);
    assign rd_k  = beat - CL_B;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_INIT;
        else        st <= st_nx;
    end

    // Next state and wait-timer loads
    always_comb begin
        st_nx    = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            ST_INIT:       if (tmr_done) st_nx = ST_PRE_ALL;
            ST_PRE_ALL: begin
                st_nx = ST_PRE_WAIT; tmr_load = 1'b1; tmr_val = TW'(T_RP - 2);
            end
            ST_PRE_WAIT:   if (tmr_done) st_nx = ST_MODE;
            ST_MODE: begin
                st_nx = ST_MODE_WAIT; tmr_load = 1'b1; tmr_val = TW'(T_MRD - 2);
            end
            ST_MODE_WAIT:  if (tmr_done) st_nx = pend ? ST_ACT : ST_IDLE;
            ST_IDLE:
                if (req_valid) st_nx = (req_len != cur_len) ? ST_MODE : ST_ACT;
            ST_ACT: begin
                st_nx = ST_ACT_WAIT; tmr_load = 1'b1; tmr_val = TW'(T_RCD - 2);
            end
            ST_ACT_WAIT:   if (tmr_done) st_nx = l_write ? ST_WRITE : ST_READ;
            ST_WRITE:
                if (!full && l_n == NW'(1)) begin
                    st_nx = ST_RECOVER; tmr_load = 1'b1; tmr_val = TW'(T_WR + T_RP - 2);
                end else begin
                    st_nx = ST_WR_BURST;
                end
            ST_WR_BURST:
                if (full) begin
                    if (beat == l_n_b) st_nx = ST_CLOSE;
                end else if (beat == l_n_b - 1'b1) begin
                    st_nx = ST_RECOVER; tmr_load = 1'b1; tmr_val = TW'(T_WR + T_RP - 2);
                end
            ST_READ:       st_nx = ST_RD_BURST;
            ST_RD_BURST:   if (beat == CL_B + l_n_b - 1'b1) st_nx = ST_CLOSE;
            ST_CLOSE: begin
                st_nx = ST_CLOSE_WAIT; tmr_load = 1'b1; tmr_val = TW'(T_RP - 2);
            end
            ST_CLOSE_WAIT: if (tmr_done) st_nx = ST_IDLE;
            ST_RECOVER:    if (tmr_done) st_nx = ST_IDLE;
            default:       st_nx = ST_IDLE;
        endcase
    end

    // Request latch, mode shadow and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_write <= 1'b0; pend <= 1'b0;
            l_bank  <= '0;   l_row <= '0; l_col <= '0;
            l_len   <= DEF_LEN; cur_len <= 3'd0;
            l_n     <= '0;   beat <= '0;
        end else begin
            if (st == ST_IDLE && req_valid) begin
                l_write <= req_write;
                l_bank  <= a_bank;
                l_row   <= a_row;
                l_col   <= a_col;
                l_len   <= req_len;
                l_n     <= words_of(req_len, req_words);
                pend    <= 1'b1;
            end else if (st == ST_ACT) begin
                pend    <= 1'b0;
            end
            if (st == ST_MODE) cur_len <= l_len;
            if (st == ST_WRITE || st == ST_READ)           beat <= BW'(1);
            else if (st == ST_WR_BURST || st == ST_RD_BURST) beat <= beat + 1'b1;
            else                                             beat <= '0;
        end
    end

    // Outputs
    always_comb begin
        cmd       = CMD_NOP;
        sd_ba     = '0;
        sd_addr   = '0;
        wr_ready  = 1'b0;
        rd_valid  = 1'b0;
        beat_k    = '0;
        unique case (st)
            ST_PRE_ALL: begin
                cmd = CMD_PRE; sd_addr[10] = 1'b1;
            end
            ST_MODE: begin
                cmd = CMD_MODE;
                sd_addr[2:0] = l_len;
                sd_addr[6:4] = 3'(CAS_LAT);
            end
            ST_ACT: begin
                cmd = CMD_ACT; sd_ba = l_bank; sd_addr = l_row;
            end
            ST_WRITE: begin
                cmd = CMD_WR; sd_ba = l_bank;
                sd_addr[COL_W-1:0] = l_col;
                sd_addr[10] = !full;
                wr_ready = 1'b1;
            end
            ST_WR_BURST: begin
                if (full && beat == l_n_b) cmd = CMD_TERM;
                else begin
                    wr_ready = 1'b1;
                    beat_k   = beat[COL_W-1:0];
                end
            end
            ST_READ: begin
                cmd = CMD_RD; sd_ba = l_bank;
                sd_addr[COL_W-1:0] = l_col;
            end
            ST_RD_BURST: begin
                if (full && beat == l_n_b) cmd = CMD_TERM;
                if (beat >= CL_B && beat < CL_B + l_n_b) begin
                    rd_valid = 1'b1;
                    beat_k   = rd_k[COL_W-1:0];
                end
            end
            ST_CLOSE: begin
                cmd = CMD_PRE; sd_ba = l_bank;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign req_ready = (st == ST_IDLE);
    assign sd_dq_oe  = wr_ready;
    assign sd_dq_out = wr_data;
    assign rd_data   = sd_dq_in;

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    logic [3:0]    since_act;
    logic [BW:0]   since_rd;
    logic          ap_open;
    logic [3:0]    pin_cmd;
    logic [COL_W-1:0] blk_mask;

    assign pin_cmd  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign blk_mask = (l_len == 3'd1) ? COL_W'(1) :
                      (l_len == 3'd2) ? COL_W'(3) :
                      (l_len == 3'd3) ? COL_W'(7) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_act <= '0; since_rd <= '0; ap_open <= 1'b0;
        end else begin
            if (pin_cmd == CMD_ACT)   since_act <= 4'd1;
            else if (since_act != 4'hF) since_act <= since_act + 1'b1;
            if (pin_cmd == CMD_RD)    since_rd <= (BW+1)'(1);
            else if (since_rd != '1)  since_rd <= since_rd + 1'b1;
            if (pin_cmd == CMD_WR && sd_addr[10]) ap_open <= 1'b1;
            else if (req_ready)                   ap_open <= 1'b0;
        end
    end

    p_col_after_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_RD || pin_cmd == CMD_WR) |-> since_act == 4'(T_RCD))
        else $error("column command not T_RCD after ACTIVE");

    p_rd_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (since_rd >= (BW+1)'(CAS_LAT) &&
                      since_rd <  (BW+1)'(CAS_LAT) + (BW+1)'(l_n)))
        else $error("read word outside latency window");

    p_wr_starts_on_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_ready) |-> pin_cmd == CMD_WR)
        else $error("write burst started without WRITE");

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (pin_cmd == CMD_NOP && !sd_dq_oe && !rd_valid))
        else $error("bus activity while idle");

    p_no_pre_after_ap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_cmd == CMD_PRE |-> !ap_open)
        else $error("PRECHARGE after auto-precharge write");

    p_term_full_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pin_cmd == CMD_TERM |-> l_len == LEN_FULL)
        else $error("terminate in fixed-length burst");

    p_len_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (req_len <= 3'd3 ||
            (req_len == LEN_FULL && req_words != '0 &&
             req_words <= NW'(1 << COL_W))))
        else $error("illegal burst length request");

    p_mode_before_act_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pin_cmd == CMD_ACT |-> cur_len == l_len)
        else $error("ACTIVE with stale mode register");

    p_col_in_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_ready || rd_valid) && !full) |->
            ((xfer_col ^ l_col) & ~blk_mask) == '0)
        else $error("word column left its burst block");

endmodule

// File: tb/sdram_burst_ctrl_test.sv
`timescale 1ns/1ps
module sdram_burst_ctrl_test;
    localparam int DW = 16, BKW = 1, RW = 12, CW = 9;
    localparam int CL = 2, RCD = 2, RP = 2, MRD = 2, TWR = 2, INIT = 16;
    localparam int AW = BKW + RW + CW;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_TERM = 4'b0110,
                           C_MODE = 4'b0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0] req_len = '0;
    logic [CW:0] req_words = '0;
    logic [DW-1:0] wr_data = '0, sd_dq_in = '0;
    logic req_ready, wr_ready, rd_valid, sd_dq_oe;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [DW-1:0] rd_data, sd_dq_out;
    logic [CW-1:0] xfer_col;
    logic [BKW-1:0] sd_ba;
    logic [RW-1:0] sd_addr;
    logic [3:0] cmdv;

    int checks = 0, errors = 0, cur_len = 3;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    assign cmdv = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    sdram_burst_ctrl #(.DATA_W(DW), .BANK_W(BKW), .ROW_W(RW), .COL_W(CW),
        .CAS_LAT(CL), .T_RCD(RCD), .T_RP(RP), .T_MRD(MRD), .T_WR(TWR),
        .INIT_CYC(INIT), .DEF_LEN(3'd3)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
        .req_words(req_words), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .xfer_col(xfer_col),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_col(input int start, input int len, input int k);
        int mask;
        mask = (len == 7) ? 511 : (1 << len) - 1;
        return ((start & ~mask) | ((start + k) & mask)) & 511;
    endfunction

    task automatic run_txn(input bit wr, input int bank, input int row,
                           input int col, input int len, input int words);
        int n, base, ci, i;
        int mode_i = -1, act_i = -1, col_i = -1, term_i = -1, pre_i = -1;
        int beats = 0, last_rd = -1, exp_pre, exp_idle;
        int mode_a = 0, act_ba = 0, act_a = 0, col_ba = 0, col_a = 0, col_cmd = 0;
        int pre_a = 0, pre_ba = 0;
        bit beat_err = 0, col_err = 0, full;
        full = (len == 7);
        n    = full ? words : (1 << len);
        base = (len != cur_len) ? MRD : 0;
        ci   = base + RCD;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_len = 3'(len);
        req_words = (CW+1)'(words);
        req_addr  = {1'(bank), 12'(row), 9'(col)};
        @(negedge clk);
        req_valid = 1'b0;
        for (i = 0; i < 1500; i++) begin
            if (i > 0) @(negedge clk);
            sd_dq_in = 16'hA000 ^ 16'(i);
            wr_data  = 16'h5000 + 16'(i);
            #1;
            if (req_ready) break;
            if (cmdv == C_MODE) begin mode_i = i; mode_a = int'(sd_addr); end
            if (cmdv == C_ACT)  begin act_i = i; act_ba = int'(sd_ba); act_a = int'(sd_addr); end
            if (cmdv == C_RD || cmdv == C_WR) begin
                col_i = i; col_cmd = int'(cmdv); col_ba = int'(sd_ba); col_a = int'(sd_addr);
            end
            if (cmdv == C_TERM) term_i = i;
            if (cmdv == C_PRE)  begin pre_i = i; pre_a = int'(sd_addr); pre_ba = int'(sd_ba); end
            if (wr_ready) begin
                if (!wr || i != col_i + beats || !sd_dq_oe || sd_dq_out != wr_data) beat_err = 1;
                if (int'(xfer_col) != exp_col(col, len, beats)) col_err = 1;
                beats++;
            end
            if (rd_valid) begin
                if (wr || i != col_i + CL + beats || rd_data != (16'hA000 ^ 16'(i))) beat_err = 1;
                if (int'(xfer_col) != exp_col(col, len, beats)) col_err = 1;
                beats++; last_rd = i;
            end
        end
        // R5 mode reload
        if (base != 0) chk(mode_i == 0 && (mode_a & 7) == len && ((mode_a >> 4) & 7) == CL,
                           "R5 mode reload", mode_i, 0);
        else chk(mode_i == -1, "R5 no reload", mode_i, -1);
        chk(act_i == base && act_ba == bank && act_a == row, "R3 ACTIVE bank/row", act_a, row);
        chk(col_i == ci && col_ba == bank && (col_a & 511) == col, "R4 column command", col_i, ci);
        chk(col_cmd == int'(wr ? C_WR : C_RD), "R2 command code", col_cmd, int'(wr ? C_WR : C_RD));
        chk(beats == n, wr ? "R6 write word count" : "R8 read word count", beats, n);
        chk(!beat_err, wr ? "R6 write word timing/data" : "R8 read word timing/data", beat_err, 0);
        chk(!col_err, "R11 word column wrap", col_err, 0);
        if (wr) chk(((col_a >> 10) & 1) == (full ? 0 : 1), full ? "R9 no auto precharge" : "R7 auto precharge bit",
                    (col_a >> 10) & 1, full ? 0 : 1);
        chk(term_i == (full ? ci + n : -1), "R9 burst terminate", term_i, full ? ci + n : -1);
        exp_pre = wr ? (full ? ci + n + 1 : -1) : ci + CL + n;
        if (wr && !full) chk(pre_i == -1, "R7 no precharge command", pre_i, -1);
        else chk(pre_i == exp_pre && ((pre_a >> 10) & 1) == 0 && pre_ba == bank,
                 "R10 precharge", pre_i, exp_pre);
        exp_idle = wr ? (full ? ci + n + 1 + RP : ci + n - 1 + TWR + RP) : ci + CL + n + RP;
        chk(i == exp_idle, "R12 ready return", i, exp_idle);
        if (!wr) chk(last_rd - act_i + 1 == 4 + n, "R8 span 4+n", last_rd - act_i + 1, 4 + n);
        cur_len = len;
    endtask

    initial begin : main
        int pre_j = -1, mode_j = -1, rdy_j = -1, pre_a = 0, mode_a = 0;
        bit early = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < INIT + 8; j++) begin
            if (j > 0) @(negedge clk);
            #1;
            if (j == 0) chk(cmdv == C_NOP && !req_ready && !sd_dq_oe && !wr_ready && !rd_valid,
                            "R1 reset state", int'(cmdv), int'(C_NOP));
            if (j < INIT && cmdv != C_NOP) early = 1;
            if (cmdv == C_PRE && pre_j < 0)   begin pre_j = j; pre_a = int'(sd_addr); end
            if (cmdv == C_MODE && mode_j < 0) begin mode_j = j; mode_a = int'(sd_addr); end
            if (req_ready && rdy_j < 0) rdy_j = j;
        end
        chk(!early, "R1 NOP during settle", early, 0);
        chk(pre_j == INIT && ((pre_a >> 10) & 1) == 1, "R1 precharge all", pre_j, INIT);
        chk(mode_j == INIT + RP && (mode_a & 7) == 3 && ((mode_a >> 4) & 7) == CL,
            "R1 load mode", mode_j, INIT + RP);
        chk(rdy_j == INIT + RP + MRD, "R1 ready after init", rdy_j, INIT + RP + MRD);

        // sweep: every fixed length, every offset in an 8-word block, both directions
        for (int code = 0; code < 4; code++)
            for (int off = 0; off < 8; off++)
                for (int d = 0; d < 2; d++)
                    run_txn(d[0], off & 1, code * 100 + off, (code * 64 + off * 9) & 511, code, 0);
        // full page, including row-end wrap
        run_txn(1'b0, 0, 7,    0,   7, 1);
        run_txn(1'b1, 1, 8,    300, 7, 3);
        run_txn(1'b0, 1, 4095, 509, 7, 5);
        run_txn(1'b1, 0, 12,   510, 7, 4);
        run_txn(1'b0, 0, 13,   100, 7, 16);
        // back to a fixed length: reload required
        run_txn(1'b1, 1, 77,   6,   2, 0);
        run_txn(1'b0, 1, 77,   6,   2, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule